// File: doc/BRIEF.md
# J1850 Link Error Detector

This block sits beside a J1850 symbol decoder and transmitter and watches for faults at the link level. Each time a symbol period ends, the decoder raises a strobe and reports the symbol it saw on the bus. The transmitter reports whether it is sending and which symbol it drove during that same period. From these inputs the block runs the message CRC, checks that end-of-data and end-of-frame markers fall on byte boundaries, and catches invalid symbols. It also compares what the transmitter drove with what came back from the bus.

Errors are recorded in four sticky flags that the CPU clears with a strobe. A priority code condenses the flags into one value, and an interrupt output follows the flags when enabled. The transmitter is told to stop the same cycle an error is seen while it is sending. CPU transmit commands are held until the bus is passive, so a bus stuck dominant never gets a transmission. A bus stuck passive is caught when the start-of-frame echo fails to appear. The block then aborts and waits for a fresh command; it never retries on its own.

Top module: `jlink_err_mon`

## Requirements
- R1: The CRC is CRC-8 with polynomial 0x1D and preset 0xFF, shifted MSB first over the data bits. When EOD arrives on a byte boundary, the register after all data and the received CRC byte must equal 0xC4; otherwise error flag bit 0 (CRC) is set.
- R2: SOF presets the CRC register and clears the bit count. Data symbols that arrive outside a frame are ignored.
- R3: A symbol of kind invalid sets flag bit 1 (symbol). Symbol codes: SOF=0, D0=1, D1=2, EOD=3, EOF=4, BRK=5, INV=6.
- R4: EOD or EOF received inside a frame when the data bit count is not a multiple of 8 sets flag bit 2 (framing).
- R5: While transmitting, if the transmitter drove EOD and the echoed symbol is an active one (SOF, D0, D1 or BRK), flag bit 2 (framing) is set.
- R6: While transmitting, if the transmitter drove SOF and the echo is not SOF (bus stuck passive), flag bit 3 (transmit fault) is set.
- R7: `tx_abort` is high in the same cycle as any error detection while `tx_active` is high.
- R8: A `tx_req` command stays pending. `tx_grant` is high only while a command is pending, `bus_lvl` is 0 (passive) and `tx_active` is 0. A bus held dominant never receives a grant.
- R9: A grant uses up its command. After an abort, no grant is issued again without a new `tx_req`.
- R10: Flags stay set until `err_clr`. An error detected in the same cycle as `err_clr` remains set.
- R11: `err_code` reports the highest-priority set flag: 4 transmit fault, 3 framing, 2 symbol, 1 CRC, 0 none.
- R12: `irq` is high exactly when `irq_en` is high and any flag is set.
- R13: After any error, received symbols are ignored until an EOF symbol or `bus_idle` is seen. The receiver then waits for the next SOF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | End-of-symbol strobe from the decoder |
| sym_kind | input | 3 | Received symbol code |
| bus_lvl | input | 1 | Sampled bus level, 1 = dominant |
| bus_idle | input | 1 | Bus has been passive long enough to count as idle |
| tx_active | input | 1 | Transmitter is driving a message |
| tx_sym | input | 3 | Symbol code the transmitter drove this period |
| tx_req | input | 1 | CPU command to start a transmission |
| irq_en | input | 1 | Interrupt enable |
| err_clr | input | 1 | CPU strobe that clears all flags |
| tx_grant | output | 1 | Permission for the transmitter to start |
| tx_abort | output | 1 | Stop driving the bus now |
| err_flags | output | 4 | Sticky flags {txfault, framing, symbol, crc} |
| err_code | output | 3 | Priority code of the set flags |
| irq | output | 1 | Interrupt request |

## Verification
A CRC register that drifts or misses a preset only becomes visible at the next EOD on a byte boundary. There it turns a good frame into a CRC flag, or hides a bad one, one cycle after the strobe. A wrong bit count shows up as a framing flag at the end marker. A receiver stuck in or out of its post-error lockout shows up as flags that appear or fail to appear for the symbols that follow. A stale pending command shows up as a grant in a cycle where none was requested. The bench models every one of these and compares all outputs on every clock, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/jlink_pkg.sv
package jlink_pkg;

    typedef enum logic [2:0] {
        SYM_SOF = 3'd0,
        SYM_D0  = 3'd1,
        SYM_D1  = 3'd2,
        SYM_EOD = 3'd3,
        SYM_EOF = 3'd4,
        SYM_BRK = 3'd5,
        SYM_INV = 3'd6
    } sym_e;

    localparam int unsigned CRC_W    = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h1D;
    localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;
    localparam logic [CRC_W-1:0] CRC_GOOD = 8'hC4;

    typedef struct packed {
        logic txf;
        logic frm;
        logic sym;
        logic crc;
    } err_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic is_active(input sym_e s);
        return (s == SYM_SOF) || (s == SYM_D0) || (s == SYM_D1) || (s == SYM_BRK);
    endfunction

    function automatic logic [2:0] err_code_of(input err_t e);
        if (e.txf)      return 3'd4;
        else if (e.frm) return 3'd3;
        else if (e.sym) return 3'd2;
        else if (e.crc) return 3'd1;
        else            return 3'd0;
    endfunction

endpackage

// File: rtl/jlink_rx_chk.sv
module jlink_rx_chk
    import jlink_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_vld,
    input  sym_e sym,
    input  logic bus_idle,
    input  logic any_err,
    output logic new_sym,
    output logic new_frm,
    output logic new_crc
);
    localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic             in_frame;
    logic             blk;
    logic [CRC_W-1:0] crc;
    logic [CNT_W-1:0] bits;
    logic             live;
    logic             on_bnd;
    logic             is_end;

    always_comb begin
        live    = sym_vld && !blk;
        on_bnd  = (bits == '0);
        is_end  = (sym == SYM_EOD) || (sym == SYM_EOF);
        new_sym = live && (sym == SYM_INV);
        new_frm = live && in_frame && is_end && !on_bnd;
        new_crc = live && in_frame && (sym == SYM_EOD) && on_bnd && (crc != CRC_GOOD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            blk      <= 1'b0;
            crc      <= CRC_INIT;
            bits     <= '0;
        end else if (any_err) begin
            blk      <= 1'b1;
            in_frame <= 1'b0;
        end else if (blk) begin
            if (bus_idle || (sym_vld && sym == SYM_EOF))
                blk <= 1'b0;
        end else if (sym_vld) begin
            case (sym)
                SYM_SOF: begin
                    in_frame <= 1'b1;
                    crc      <= CRC_INIT;
                    bits     <= '0;
                end
                SYM_D0, SYM_D1: begin
                    if (in_frame) begin
                        crc  <= crc_step(crc, sym == SYM_D1);
                        bits <= (bits == CNT_W'(BYTE_W - 1)) ? '0 : bits + 1'b1;
                    end
                end
                SYM_EOD, SYM_EOF: in_frame <= 1'b0;
                default: ;
            endcase
        end
    end

    // R2: an accepted SOF opens a frame with a fresh CRC and bit count
    assert_sof_reset_R2: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && !blk && sym == SYM_SOF && !any_err) |=> (in_frame && bits == '0 && crc == CRC_INIT));

    // R13: lockout persists while no release condition is seen
    assert_lockout_R13: assert property (@(posedge clk) disable iff (rst)
        (blk && !bus_idle && !(sym_vld && sym == SYM_EOF)) |=> blk);

endmodule

// File: rtl/jlink_tx_guard.sv
module jlink_tx_guard
    import jlink_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_req,
    input  logic bus_lvl,
    input  logic tx_active,
    input  logic sym_vld,
    input  sym_e sym,
    input  sym_e tx_sym,
    output logic grant,
    output logic new_txf,
    output logic new_frm
);
    logic pend;
    logic chk;

    always_comb begin
        grant   = pend && !bus_lvl && !tx_active;
        chk     = sym_vld && tx_active;
        new_txf = chk && (tx_sym == SYM_SOF) && (sym != SYM_SOF);
        new_frm = chk && (tx_sym == SYM_EOD) && is_active(sym);
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= tx_req || (pend && !grant);
    end

    // R9: a grant consumes the command; no second grant without a new request
    assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (grant && !tx_req) |=> !grant);

endmodule

// File: rtl/jlink_err_flags.sv
module jlink_err_flags
    import jlink_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       irq_en,
    input  err_t       new_err,
    output err_t       flags,
    output logic [2:0] code,
    output logic       irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (clr ? err_t'('0) : flags) | new_err;
    end

    always_comb begin
        code = err_code_of(flags);
        irq  = irq_en && (flags != '0);
    end

    // R10: without a clear no flag ever drops
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R12: a detection with interrupts enabled is seen as a request next cycle
    assert_irq_follow_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_en && !$past(rst) && ($past(new_err) != '0)) |-> irq);

endmodule

// File: rtl/jlink_err_mon.sv
module jlink_err_mon
    import jlink_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_vld,
    input  logic [2:0] sym_kind,
    input  logic       bus_lvl,
    input  logic       bus_idle,
    input  logic       tx_active,
    input  logic [2:0] tx_sym,
    input  logic       tx_req,
    input  logic       irq_en,
    input  logic       err_clr,
    output logic       tx_grant,
    output logic       tx_abort,
    output logic [3:0] err_flags,
    output logic [2:0] err_code,
    output logic       irq
);
    sym_e rx_s;
    sym_e tx_s;
    logic r_sym, r_frm, r_crc;
    logic t_txf, t_frm;
    err_t new_err;
    err_t flags;
    logic any_err;

    assign rx_s = sym_e'(sym_kind);
    assign tx_s = sym_e'(tx_sym);

    jlink_rx_chk #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sym_vld  (sym_vld),
        .sym      (rx_s),
        .bus_idle (bus_idle),
        .any_err  (any_err),
        .new_sym  (r_sym),
        .new_frm  (r_frm),
        .new_crc  (r_crc)
    );

    jlink_tx_guard u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_req    (tx_req),
        .bus_lvl   (bus_lvl),
        .tx_active (tx_active),
        .sym_vld   (sym_vld),
        .sym       (rx_s),
        .tx_sym    (tx_s),
        .grant     (tx_grant),
        .new_txf   (t_txf),
        .new_frm   (t_frm)
    );

    always_comb begin
        new_err.txf = t_txf;
        new_err.frm = r_frm || t_frm;
        new_err.sym = r_sym;
        new_err.crc = r_crc;
        any_err     = (new_err != '0);
        tx_abort    = tx_active && any_err;
    end

    jlink_err_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (err_clr),
        .irq_en  (irq_en),
        .new_err (new_err),
        .flags   (flags),
        .code    (err_code),
        .irq     (irq)
    );

    assign err_flags = flags;

    // R7: every abort leaves a recorded flag behind
    assert_abort_flags_R7: assert property (@(posedge clk) disable iff (rst)
        tx_abort |=> (err_flags != 4'd0));

endmodule

// File: tb/jlink_err_mon_tb.sv
module jlink_err_mon_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_vld = 1'b0;
    logic [2:0] sym_kind = 3'd0;
    logic       bus_lvl = 1'b0;
    logic       bus_idle = 1'b0;
    logic       tx_active = 1'b0;
    logic [2:0] tx_sym = 3'd0;
    logic       tx_req = 1'b0;
    logic       irq_en = 1'b1;
    logic       err_clr = 1'b0;
    logic       tx_grant, tx_abort, irq;
    logic [3:0] err_flags;
    logic [2:0] err_code;

    always #10 clk = ~clk;

    jlink_err_mon u_dut (
        .clk(clk), .rst(rst), .sym_vld(sym_vld), .sym_kind(sym_kind),
        .bus_lvl(bus_lvl), .bus_idle(bus_idle), .tx_active(tx_active),
        .tx_sym(tx_sym), .tx_req(tx_req), .irq_en(irq_en), .err_clr(err_clr),
        .tx_grant(tx_grant), .tx_abort(tx_abort), .err_flags(err_flags),
        .err_code(err_code), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R0";

    // behavioural reference state
    bit   m_inf = 0, m_blk = 0, m_pend = 0;
    bit [3:0] m_fl = 0;
    bit   rx_bits[$];

    function automatic int crc_over(input bit q[$]);
        int c = 255;
        foreach (q[i]) begin
            int top = (c >> 7) & 1;
            c = (c << 1) & 255;
            if (top != int'(q[i])) c = c ^ 29;
        end
        return c;
    endfunction

    function automatic int code_ref(input bit [3:0] f);
        if (f[3]) return 4;
        if (f[2]) return 3;
        if (f[1]) return 2;
        if (f[0]) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        int k; bit live, e_sym, e_frm, e_crc, e_txf, any, g_exp, a_exp;
        #1;
        k = int'(sym_kind);
        live  = sym_vld && !m_blk && !rst;
        e_sym = live && k == 6;
        e_frm = live && m_inf && (k == 3 || k == 4) && (rx_bits.size() % 8 != 0);
        e_crc = live && m_inf && k == 3 && (rx_bits.size() % 8 == 0) && crc_over(rx_bits) != 196;
        e_txf = 0;
        if (sym_vld && tx_active && !rst) begin
            if (tx_sym == 3'd0 && k != 0) e_txf = 1;
            if (tx_sym == 3'd3 && (k == 0 || k == 1 || k == 2 || k == 5)) e_frm = 1;
        end
        any   = e_sym || e_frm || e_crc || e_txf;
        g_exp = m_pend && !bus_lvl && !tx_active;
        a_exp = tx_active && any;
        chk(tx_grant == g_exp, "R8", "grant", tx_grant, g_exp);
        chk(tx_abort == a_exp, "R7", "abort", tx_abort, a_exp);
        chk(err_flags == m_fl, tag, "flags", err_flags, m_fl);
        chk(int'(err_code) == code_ref(m_fl), "R11", "code", err_code, code_ref(m_fl));
        chk(irq == (irq_en && m_fl != 0), "R12", "irq", irq, irq_en && m_fl != 0);
        @(posedge clk);
        if (rst) begin
            m_inf = 0; m_blk = 0; m_pend = 0; m_fl = 0; rx_bits.delete();
        end else begin
            m_pend = tx_req || (m_pend && !g_exp);
            m_fl = (err_clr ? 4'd0 : m_fl) | {e_txf, e_frm, e_sym, e_crc};
            if (any) begin
                m_blk = 1; m_inf = 0;
            end else if (m_blk) begin
                if (bus_idle || (sym_vld && k == 4)) m_blk = 0;
            end else if (sym_vld) begin
                if (k == 0) begin m_inf = 1; rx_bits.delete(); end
                else if ((k == 1 || k == 2) && m_inf) rx_bits.push_back(k == 2);
                else if (k == 3 || k == 4) m_inf = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic sym(input int k);
        sym_vld = 1; sym_kind = 3'(k);
        step();
        sym_vld = 0; sym_kind = 3'd0;
    endtask

    task automatic send_byte(input bit [7:0] b);
        for (int i = 7; i >= 0; i--) sym(b[i] ? 2 : 1);
    endtask

    function automatic bit [7:0] crc_bytes(input bit [7:0] d[$]);
        bit q[$];
        foreach (d[j]) for (int i = 7; i >= 0; i--) q.push_back(d[j][i]);
        return 8'(crc_over(q));
    endfunction

    task automatic frame(input bit [7:0] d[$], input bit [7:0] crc_xor);
        bit [7:0] c;
        c = ~crc_bytes(d) ^ crc_xor;
        sym(0);
        foreach (d[j]) send_byte(d[j]);
        send_byte(c);
        sym(3);
    endtask

    task automatic clear();
        err_clr = 1; step(); err_clr = 0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R10"; idle(3);          // reset state
        rst = 0; idle(2);

        tag = "R1"; frame('{8'h12, 8'h34}, 8'h00); sym(4); idle(2);

        tag = "R2"; sym(2); sym(2); sym(1);
        frame('{8'hA5}, 8'h00); sym(4); idle(2);

        tag = "R1"; frame('{8'h12}, 8'h01); idle(1); sym(4); idle(2);

        tag = "R10"; idle(3); clear(); idle(2);

        tag = "R3"; sym(0); sym(1); sym(2); sym(1); sym(6);
        tag = "R13"; sym(2); sym(2); sym(1); sym(3); sym(6); idle(1);
        bus_idle = 1; step(); bus_idle = 0;
        tag = "R4"; sym(0); sym(1); sym(1); sym(2); sym(3); idle(2);
        clear(); sym(4);

        tag = "R12"; irq_en = 0; sym(6); idle(2); irq_en = 1; idle(2); clear(); sym(4);

        tag = "R8"; bus_lvl = 1; tx_req = 1; step(); tx_req = 0; idle(10);
        bus_lvl = 0; idle(2);

        tag = "R6"; tx_active = 1; tx_sym = 3'd0; sym(6); tx_active = 0;
        tag = "R9"; idle(10); clear(); sym(4); idle(1);

        tag = "R5"; tx_req = 1; step(); tx_req = 0; idle(1);
        tx_active = 1; tx_sym = 3'd0; sym(0);
        tx_sym = 3'd2; sym(2);
        tx_sym = 3'd3; sym(2);
        tx_active = 0; tx_sym = 3'd0; idle(2); clear(); sym(4);

        tag = "R10"; err_clr = 1; sym_vld = 1; sym_kind = 3'd6; step();
        err_clr = 0; sym_vld = 0; sym_kind = 3'd0; idle(3);
        clear(); sym(4); idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule